// File: doc/BRIEF.md
# Rotating-Priority Cascaded Interrupt Resolver

This block picks which interrupt to hand to a processor when that processor acknowledges. Two eight-input controllers are chained. The primary controller comes first. One of its inputs, the cascade position, does not carry a request of its own: it stands for the secondary controller as a whole. On an acknowledge strobe, the resolver first searches the primary request register for an unmasked request. It looks at the secondary controller only when the primary has nothing to grant. It then returns a 16-bit vector and the bit masks that the surrounding controller uses to update its request and in-service registers.

Each controller supplies a 3-bit pointer that names its lowest-priority position. The search in that controller starts one position above the pointer and wraps through all eight positions. Moving the pointer therefore rotates the priority order. The resolver holds no request or in-service state of its own. Command decoding and request latching stay in the surrounding logic, which applies the clear and set masks in the cycle after a grant.

Top module: `irq_resolver`

## Requirements
- R1: Within a controller, the search visits positions (low + 1) mod 8, (low + 2) mod 8, and so on, wrapping from 7 to 0. The first candidate in this order wins.
- R2: A candidate has its request bit at 1 and its mask bit at 0. In the primary controller, position 2 (the cascade) is never a candidate.
- R3: A primary grant at index i makes `pri_req_clr_o` and `pri_isr_set_o` both equal to the one-hot bit i. It also sets `valid_o` to 1 and `vec_o` to {8'h00, pri_base + i}.
- R4: The secondary controller is searched only when the primary has no candidate. A secondary grant at index j sets bit j in `sec_req_clr_o` and `sec_isr_set_o`, and sets bit 2 in `pri_req_clr_o` and `pri_isr_set_o`. It returns {8'h00, sec_base + j}.
- R5: The result is `vec_o` = 16'hFFFF, `valid_o` = 0 and every mask zero in two cases: when neither controller has a candidate, and when neither asserted input is 1.
- R6: After a primary grant, `pri_asserted_clr_o` is 1 exactly when the primary request register, with the granted bit removed, is zero.
- R7: After a secondary grant, `sec_asserted_clr_o` is 1 when the secondary request register, with the granted bit removed, is zero. `pri_asserted_clr_o` is 1 only if that holds and the primary request register, without bit 2, is also zero.
- R8: All outputs are registered. They reflect an `ack_i` from the previous clock edge. In any cycle not preceded by an ack, and during reset, the outputs are idle (16'hFFFF, valid 0, masks zero).
- R9: The vector is an 8-bit sum that wraps modulo 256 before it is zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_i | input | 1 | Single-cycle acknowledge strobe |
| pri_req_i | input | 8 | Primary request register |
| pri_mask_i | input | 8 | Primary mask register |
| pri_low_i | input | 3 | Primary lowest-priority pointer |
| pri_base_i | input | 8 | Primary vector base |
| pri_asserted_i | input | 1 | Primary marked as asserting |
| sec_req_i | input | 8 | Secondary request register |
| sec_mask_i | input | 8 | Secondary mask register |
| sec_low_i | input | 3 | Secondary lowest-priority pointer |
| sec_base_i | input | 8 | Secondary vector base |
| sec_asserted_i | input | 1 | Secondary marked as asserting |
| vec_o | output | 16 | Granted vector, or 16'hFFFF |
| valid_o | output | 1 | A grant was made |
| pri_req_clr_o | output | 8 | Primary request bits to clear |
| pri_isr_set_o | output | 8 | Primary in-service bits to set |
| sec_req_clr_o | output | 8 | Secondary request bits to clear |
| sec_isr_set_o | output | 8 | Secondary in-service bits to set |
| pri_asserted_clr_o | output | 1 | Clear the primary asserted flag |
| sec_asserted_clr_o | output | 1 | Clear the secondary asserted flag |

## Verification
The assertions check several structural rules on every cycle. Each mask is one-hot or zero, and every clear mask matches its set mask. A secondary grant always carries the cascade bit, while a primary grant never selects it. An idle output always shows the sentinel, and nothing is granted without an ack on the edge before. Whether the grant lands on the right index for a given pointer, the right base and wrapped sum, and the right clear decision for the asserted flags can only be shown by the bench's scenarios, which feed chosen registers and compare against known results.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
    localparam int LANES  = 8;
    localparam int BASE_W = 8;
    localparam int VEC_W  = 16;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             valid;
        logic [LANES-1:0] p_clr;
        logic [LANES-1:0] p_set;
        logic [LANES-1:0] s_clr;
        logic [LANES-1:0] s_set;
        logic             p_done;
        logic             s_done;
    } res_t;
endpackage

// File: rtl/irq_rot_pick.sv
// Rotating first-hit finder: scans from low_i+1 upward, wrapping. LANES must be a power of two.
module irq_rot_pick #(
    parameter  int LANES = 8,
    localparam int IW    = $clog2(LANES)
) (
    input  logic [LANES-1:0] cand_i,
    input  logic [IW-1:0]    low_i,
    output logic             hit_o,
    output logic [IW-1:0]    idx_o
);
    logic [IW-1:0] pos;

    // Walk from the last slot toward the first so the earliest slot overwrites.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        pos   = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            pos = low_i + IW'(k + 1);
            if (cand_i[pos]) begin
                hit_o = 1'b1;
                idx_o = pos;
            end
        end
    end
endmodule

// File: rtl/irq_lane_grant.sv
// Turns a chosen index into a one-hot mask, a vector and the leftover request set.
module irq_lane_grant #(
    parameter  int LANES  = 8,
    parameter  int BASE_W = 8,
    parameter  int VEC_W  = 16,
    localparam int IW     = $clog2(LANES)
) (
    input  logic              en_i,
    input  logic [IW-1:0]     idx_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic [LANES-1:0]  req_i,
    output logic [LANES-1:0]  onehot_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              empty_o
);
    logic [BASE_W-1:0] sum;

    always_comb begin
        onehot_o = en_i ? (LANES'(1) << idx_i) : '0;
        sum      = base_i + BASE_W'(idx_i);
        vec_o    = {{(VEC_W - BASE_W){1'b0}}, sum};
        empty_o  = ((req_i & ~onehot_o) == '0);
    end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_res_pkg::*;
#(
    parameter  int CASCADE_POS = 2,
    localparam int IW          = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_i,
    input  logic [LANES-1:0]  pri_req_i,
    input  logic [LANES-1:0]  pri_mask_i,
    input  logic [IW-1:0]     pri_low_i,
    input  logic [BASE_W-1:0] pri_base_i,
    input  logic              pri_asserted_i,
    input  logic [LANES-1:0]  sec_req_i,
    input  logic [LANES-1:0]  sec_mask_i,
    input  logic [IW-1:0]     sec_low_i,
    input  logic [BASE_W-1:0] sec_base_i,
    input  logic              sec_asserted_i,
    output logic [VEC_W-1:0]  vec_o,
    output logic              valid_o,
    output logic [LANES-1:0]  pri_req_clr_o,
    output logic [LANES-1:0]  pri_isr_set_o,
    output logic [LANES-1:0]  sec_req_clr_o,
    output logic [LANES-1:0]  sec_isr_set_o,
    output logic              pri_asserted_clr_o,
    output logic              sec_asserted_clr_o
);
    localparam logic [LANES-1:0] CAS_BIT = LANES'(1) << CASCADE_POS;

    res_t res_d, res_q;

    logic [LANES-1:0] p_cand, s_cand;
    logic             p_hit, s_hit;
    logic [IW-1:0]    p_idx, s_idx;
    logic [LANES-1:0] p_one, s_one;
    logic [VEC_W-1:0] p_vec, s_vec;
    logic             p_empty, s_empty;
    logic             gate;

    assign p_cand = pri_req_i & ~pri_mask_i & ~CAS_BIT;   // R2 cascade excluded
    assign s_cand = sec_req_i & ~sec_mask_i;
    assign gate   = ack_i & (pri_asserted_i | sec_asserted_i);

    irq_rot_pick #(.LANES(LANES)) u_pick_pri (
        .cand_i(p_cand), .low_i(pri_low_i), .hit_o(p_hit), .idx_o(p_idx));
    irq_rot_pick #(.LANES(LANES)) u_pick_sec (
        .cand_i(s_cand), .low_i(sec_low_i), .hit_o(s_hit), .idx_o(s_idx));

    irq_lane_grant #(.LANES(LANES), .BASE_W(BASE_W), .VEC_W(VEC_W)) u_form_pri (
        .en_i(p_hit), .idx_i(p_idx), .base_i(pri_base_i), .req_i(pri_req_i),
        .onehot_o(p_one), .vec_o(p_vec), .empty_o(p_empty));
    irq_lane_grant #(.LANES(LANES), .BASE_W(BASE_W), .VEC_W(VEC_W)) u_form_sec (
        .en_i(s_hit), .idx_i(s_idx), .base_i(sec_base_i), .req_i(sec_req_i),
        .onehot_o(s_one), .vec_o(s_vec), .empty_o(s_empty));

    always_comb begin
        res_d        = '0;
        res_d.vec    = '1;
        if (gate && p_hit) begin
            res_d.vec    = p_vec;
            res_d.valid  = 1'b1;
            res_d.p_clr  = p_one;
            res_d.p_set  = p_one;
            res_d.p_done = p_empty;
        end else if (gate && s_hit) begin
            res_d.vec    = s_vec;
            res_d.valid  = 1'b1;
            res_d.s_clr  = s_one;
            res_d.s_set  = s_one;
            res_d.p_clr  = CAS_BIT;
            res_d.p_set  = CAS_BIT;
            res_d.s_done = s_empty;
            res_d.p_done = s_empty && ((pri_req_i & ~CAS_BIT) == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            res_q.vec <= '1;
        end else begin
            res_q <= res_d;
        end
    end

    assign vec_o              = res_q.vec;
    assign valid_o            = res_q.valid;
    assign pri_req_clr_o      = res_q.p_clr;
    assign pri_isr_set_o      = res_q.p_set;
    assign sec_req_clr_o      = res_q.s_clr;
    assign sec_isr_set_o      = res_q.s_set;
    assign pri_asserted_clr_o = res_q.p_done;
    assign sec_asserted_clr_o = res_q.s_done;
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
    parameter int LANES       = 8,
    parameter int VEC_W       = 16,
    parameter int CASCADE_POS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_i,
    input logic [VEC_W-1:0] vec_o,
    input logic             valid_o,
    input logic [LANES-1:0] pri_req_clr_o,
    input logic [LANES-1:0] pri_isr_set_o,
    input logic [LANES-1:0] sec_req_clr_o,
    input logic [LANES-1:0] sec_isr_set_o,
    input logic             pri_asserted_clr_o,
    input logic             sec_asserted_clr_o
);
    a_r5_idle_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (vec_o == '1 && pri_isr_set_o == '0 && sec_isr_set_o == '0));

    a_r3_pri_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pri_isr_set_o) && $onehot0(sec_isr_set_o));

    a_r3_clr_matches_set: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_req_clr_o == pri_isr_set_o) && (sec_req_clr_o == sec_isr_set_o));

    a_r4_cascade_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_isr_set_o != '0) |-> (valid_o && pri_isr_set_o[CASCADE_POS]));

    a_r2_cascade_not_primary: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && sec_isr_set_o == '0) |-> !pri_isr_set_o[CASCADE_POS]);

    a_r8_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> !valid_o);

    a_r7_flags_need_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_asserted_clr_o || sec_asserted_clr_o) |-> valid_o);

    a_r7_sec_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        sec_asserted_clr_o |-> (sec_isr_set_o != '0));
endmodule

bind irq_resolver irq_resolver_chk #(
    .LANES(irq_res_pkg::LANES), .VEC_W(irq_res_pkg::VEC_W), .CASCADE_POS(CASCADE_POS)
) u_chk (.*);

// File: tb/tb_irq_resolver.sv
`timescale 1ns/1ps
module tb_irq_resolver;
    logic        clk = 1'b0;
    logic        rst_n, ack_i;
    logic [7:0]  pri_req_i, pri_mask_i, pri_base_i, sec_req_i, sec_mask_i, sec_base_i;
    logic [2:0]  pri_low_i, sec_low_i;
    logic        pri_asserted_i, sec_asserted_i;
    logic [15:0] vec_o;
    logic        valid_o, pri_asserted_clr_o, sec_asserted_clr_o;
    logic [7:0]  pri_req_clr_o, pri_isr_set_o, sec_req_clr_o, sec_isr_set_o;

    int n_run = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_resolver dut (.*);

    typedef struct packed {
        logic [7:0]  preq, pmask; logic [2:0] plow;
        logic [7:0]  sreq, smask; logic [2:0] slow;
        logic [7:0]  pb, sb; logic [1:0] as_;
        logic [15:0] evec; logic evld;
        logic [7:0]  ep, es; logic epa, esa;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{8'h01,8'h00,3'd7,8'h00,8'h00,3'd7,8'h08,8'h70,2'b01,16'h0008,1'b1,8'h01,8'h00,1'b1,1'b0}, // R1 R6
        '{8'h88,8'h00,3'd3,8'h00,8'h00,3'd7,8'h08,8'h70,2'b01,16'h000F,1'b1,8'h80,8'h00,1'b0,1'b0}, // R1 rotated
        '{8'h88,8'h00,3'd7,8'h00,8'h00,3'd7,8'h08,8'h70,2'b01,16'h000B,1'b1,8'h08,8'h00,1'b0,1'b0}, // R1
        '{8'h88,8'h08,3'd7,8'h00,8'h00,3'd7,8'h08,8'h70,2'b01,16'h000F,1'b1,8'h80,8'h00,1'b0,1'b0}, // R2 mask
        '{8'h04,8'h00,3'd7,8'h20,8'h00,3'd7,8'h08,8'h70,2'b11,16'h0075,1'b1,8'h04,8'h20,1'b1,1'b1}, // R4 R7
        '{8'h06,8'h02,3'd7,8'h21,8'h00,3'd0,8'h08,8'h70,2'b11,16'h0075,1'b1,8'h04,8'h20,1'b0,1'b0}, // R4 R7
        '{8'h05,8'h00,3'd7,8'h01,8'h00,3'd7,8'h08,8'h70,2'b11,16'h0008,1'b1,8'h01,8'h00,1'b0,1'b0}, // R4 primary first
        '{8'hFF,8'hFF,3'd7,8'h00,8'h00,3'd7,8'h08,8'h70,2'b01,16'hFFFF,1'b0,8'h00,8'h00,1'b0,1'b0}, // R5
        '{8'h01,8'h00,3'd7,8'h00,8'h00,3'd7,8'h08,8'h70,2'b00,16'hFFFF,1'b0,8'h00,8'h00,1'b0,1'b0}, // R5 not asserted
        '{8'h08,8'h00,3'd7,8'h00,8'h00,3'd7,8'hFE,8'h70,2'b01,16'h0001,1'b1,8'h08,8'h00,1'b1,1'b0}, // R9 wrap
        '{8'h04,8'h00,3'd7,8'h80,8'h80,3'd7,8'h08,8'h70,2'b11,16'hFFFF,1'b0,8'h00,8'h00,1'b0,1'b0}, // R2 R5
        '{8'h03,8'h00,3'd1,8'h00,8'h00,3'd7,8'h08,8'h70,2'b01,16'h0008,1'b1,8'h01,8'h00,1'b0,1'b0}, // R1 wrap
        '{8'h04,8'h04,3'd7,8'h02,8'h00,3'd1,8'h08,8'h70,2'b11,16'h0071,1'b1,8'h04,8'h02,1'b1,1'b1}  // R4 R7
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " vec"}, 32'(vec_o), 32'hFFFF);
        chk({tag, " valid"}, 32'(valid_o), 32'h0);
        chk({tag, " masks"}, {pri_req_clr_o, pri_isr_set_o, sec_req_clr_o, sec_isr_set_o}, 32'h0);
    endtask

    task automatic apply(input vec_t v);
        pri_req_i = v.preq; pri_mask_i = v.pmask; pri_low_i = v.plow; pri_base_i = v.pb;
        sec_req_i = v.sreq; sec_mask_i = v.smask; sec_low_i = v.slow; sec_base_i = v.sb;
        pri_asserted_i = v.as_[0]; sec_asserted_i = v.as_[1];
    endtask

    initial begin
        #(8 * 50000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ack_i = 1'b0;
        apply(TBL[0]);
        repeat (3) @(negedge clk);
        chk_idle("R8 reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R8: pending request without ack stays idle
        repeat (2) @(negedge clk);
        chk_idle("R8 no ack");

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            ack_i = 1'b1;
            @(negedge clk);
            ack_i = 1'b0;
            chk($sformatf("R1/R3/R4/R9 vec #%0d", i), 32'(vec_o), 32'(TBL[i].evec));
            chk($sformatf("R5 valid #%0d", i), 32'(valid_o), 32'(TBL[i].evld));
            chk($sformatf("R3/R4 pri clr #%0d", i), 32'(pri_req_clr_o), 32'(TBL[i].ep));
            chk($sformatf("R3/R4 pri set #%0d", i), 32'(pri_isr_set_o), 32'(TBL[i].ep));
            chk($sformatf("R4 sec clr #%0d", i), 32'(sec_req_clr_o), 32'(TBL[i].es));
            chk($sformatf("R4 sec set #%0d", i), 32'(sec_isr_set_o), 32'(TBL[i].es));
            chk($sformatf("R6/R7 pri flag #%0d", i), 32'(pri_asserted_clr_o), 32'(TBL[i].epa));
            chk($sformatf("R7 sec flag #%0d", i), 32'(sec_asserted_clr_o), 32'(TBL[i].esa));
            @(negedge clk);
            chk_idle($sformatf("R8 strobe drop #%0d", i));
        end

        // R8: reset wins over a simultaneous ack
        apply(TBL[0]);
        ack_i = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        ack_i = 1'b0; rst_n = 1'b1;
        chk_idle("R8 reset over ack");

        // R1: every pointer value with all lines pending picks low+1 (skipping the cascade)
        for (int p = 0; p < 8; p++) begin
            pri_req_i = 8'hFF; pri_mask_i = 8'h00; pri_low_i = 3'(p); pri_base_i = 8'h20;
            pri_asserted_i = 1'b1; sec_asserted_i = 1'b0; sec_req_i = 8'h00;
            ack_i = 1'b1;
            @(negedge clk);
            ack_i = 1'b0;
            chk($sformatf("R1 sweep low=%0d", p), 32'(vec_o),
                32'h20 + ((((p + 1) % 8) == 2) ? 32'd3 : 32'((p + 1) % 8)));
            @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule